// File: doc/BRIEF.md
# Address-Driven Glitch-Free Clock Switch

This block supplies the processor's phase-2 clock from one of two related sources. The fast source runs at four fifths of a base oscillator, and the slow source runs at the base divided by four. The choice is made per access. The same address-decode line that enables the slow external memory also asks for the slow clock. The processor therefore runs slowly only while that memory is addressed, and at full speed on every other bus cycle. The slow period is chosen long enough to cover the external memory's access time.

Each source has its own short enable chain, clocked on that source's falling edge. A chain starts to fill only when the opposite chain is completely empty. The output is the OR of each source ANDed with its own enable. An enable can change only while its own clock is low, and the two enables are never on together. For these reasons the output never carries a runt high or low pulse, even when the select line moves again before a change-over has finished. Reset selects the fast source.

Top module: `clk_switch`

## Requirements
- R1: While reset is held (rst_n low) and directly after it is released, cpu_clk follows clk_fast, whatever the value of slow_sel.
- R2: With slow_sel held at 1, cpu_clk follows clk_slow: each high and low phase equals the slow source's half period.
- R3: With slow_sel held at 0, cpu_clk follows clk_fast: each high phase equals the fast source's high time.
- R4: The two source enables are never on together. The incoming enable turns on only after every stage of the outgoing chain is empty.
- R5: No high or low pulse on cpu_clk is shorter than the shorter half period of the two sources. This holds for any timing of slow_sel, including a reversal during a change-over.
- R6: Every high pulse on cpu_clk is a whole high phase of exactly one source. Its width equals the high time of clk_fast or of clk_slow, and is never a clipped or merged shape.
- R7: A change of slow_sel takes effect within (SYNC_STAGES+1) periods of the outgoing clock plus (SYNC_STAGES+1) periods of the incoming clock. After that window, the next high pulse has the new source's width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast source clock (4/5 of the base oscillator) |
| clk_slow | input | 1 | Slow source clock (base oscillator divided by 4) |
| rst_n | input | 1 | Asynchronous reset, active low; selects the fast source |
| slow_sel | input | 1 | Address decode for the slow memory region; 1 asks for the slow clock |
| cpu_clk | output | 1 | Gated phase-2 clock to the processor |

## Verification
Two of the block's actions can overlap. A change-over can still be draining the outgoing chain when slow_sel reverses and asks for the other source again. The bench provokes this with directed reversals that come 25 ns after a change. It also uses random select toggles, with hold times shorter than the change-over window and at times that are not aligned to either clock. A monitor measures every edge of cpu_clk. It judges each pulse against the shorter half period and each high pulse against the two legal source high times, and it confirms that the selection settles on the final request.

// File: rtl/clk_switch.sv
`timescale 1ns/1ps
module clk_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_fast,
  input  logic clk_slow,
  input  logic rst_n,
  input  logic slow_sel,
  output logic cpu_clk
);

  logic [SYNC_STAGES-1:0] fast_q;
  logic [SYNC_STAGES-1:0] slow_q;
  logic fast_req, slow_req;
  logic fast_on, slow_on;

  assign fast_req = ~slow_sel & ~(|slow_q);
  assign slow_req =  slow_sel & ~(|fast_q);

  always_ff @(negedge clk_fast or negedge rst_n)
    if (!rst_n) fast_q <= '1;
    else        fast_q <= {fast_q[SYNC_STAGES-2:0], fast_req};

  always_ff @(negedge clk_slow or negedge rst_n)
    if (!rst_n) slow_q <= '0;
    else        slow_q <= {slow_q[SYNC_STAGES-2:0], slow_req};

  assign fast_on = fast_q[SYNC_STAGES-1];
  assign slow_on = slow_q[SYNC_STAGES-1];

  assign cpu_clk = (clk_fast & fast_on) | (clk_slow & slow_on);

  always @(negedge clk_fast)
    if (!rst_n)
      a_r1_reset_state: assert (fast_on && !slow_on)
        else $error("R1: reset must select the fast source");

  a_r4_exclusive: assert property (@(negedge clk_fast) disable iff (!rst_n)
    !(fast_on && slow_on))
    else $error("R4: both enables on");

  a_r4_slow_waits: assert property (@(negedge clk_slow) disable iff (!rst_n)
    $rose(slow_on) |-> (fast_q == '0))
    else $error("R4: slow enable rose before fast chain drained");

  a_r4_fast_waits: assert property (@(negedge clk_fast) disable iff (!rst_n)
    $rose(fast_on) |-> (slow_q == '0))
    else $error("R4: fast enable rose before slow chain drained");

endmodule

// File: tb/clk_switch_bench.sv
`timescale 1ns/1ps
module clk_switch_bench;
  localparam real FAST_HALF = 10.0;
  localparam real SLOW_HALF = 32.0;
  localparam real MIN_HALF  = 10.0;
  localparam real TOL       = 0.1;

  logic clk_fast = 1'b0, clk_slow = 1'b0, rst_n = 1'b1, slow_sel = 1'b0;
  logic cpu_clk;

  int checks = 0, errors = 0;
  int runt_cnt = 0, shape_cnt = 0, pulse_cnt = 0;
  bit mon_en = 1'b0, have_last = 1'b0, done = 1'b0;
  realtime last_edge;

  clk_switch u_clk_switch (.clk_fast(clk_fast), .clk_slow(clk_slow),
                           .rst_n(rst_n), .slow_sel(slow_sel), .cpu_clk(cpu_clk));

  always #(FAST_HALF) clk_fast = ~clk_fast;
  initial begin #3; forever #(SLOW_HALF) clk_slow = ~clk_slow; end

  function automatic bit near(real a, real b);
    return (a > b - TOL) && (a < b + TOL);
  endfunction

  always @(cpu_clk) begin
    if (mon_en) begin
      if (have_last) begin
        real w;
        w = $realtime - last_edge;
        pulse_cnt++;
        if (w < MIN_HALF - TOL) runt_cnt++;
        if (cpu_clk == 1'b0 && !near(w, FAST_HALF) && !near(w, SLOW_HALF)) shape_cnt++;
      end
      have_last = 1'b1;
      last_edge = $realtime;
    end
  end

  task automatic check(bit ok, string req, string what, real act, real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  task automatic high_width(output real w);
    realtime t;
    @(posedge cpu_clk); t = $realtime;
    @(negedge cpu_clk); w = $realtime - t;
  endtask

  task automatic low_width(output real w);
    realtime t;
    @(negedge cpu_clk); t = $realtime;
    @(posedge cpu_clk); w = $realtime - t;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    real w;
    #1 rst_n = 1'b0;
    slow_sel = 1'b1;
    high_width(w);
    check(near(w, FAST_HALF), "R1", "high width in reset, select=1", w, FAST_HALF);
    #97 slow_sel = 1'b0;
    #105 rst_n = 1'b1;
    high_width(w);
    check(near(w, FAST_HALF), "R1", "high width after reset", w, FAST_HALF);
    mon_en = 1'b1;

    #13 slow_sel = 1'b1;
    #400;
    high_width(w);
    check(near(w, SLOW_HALF), "R2", "slow high width", w, SLOW_HALF);
    low_width(w);
    check(near(w, SLOW_HALF), "R2", "slow low width", w, SLOW_HALF);

    #7 slow_sel = 1'b0;
    #400;
    high_width(w);
    check(near(w, FAST_HALF), "R3", "fast high width", w, FAST_HALF);
    low_width(w);
    check(near(w, FAST_HALF), "R3", "fast low width", w, FAST_HALF);

    // R7: bound is 3*(20+64)=252 ns for two stages
    #11 slow_sel = 1'b1;
    #255;
    high_width(w);
    check(near(w, SLOW_HALF), "R7", "slow width after latency bound", w, SLOW_HALF);
    #5 slow_sel = 1'b0;
    #255;
    high_width(w);
    check(near(w, FAST_HALF), "R7", "fast width after latency bound", w, FAST_HALF);

    // R5 corner: reversal in the middle of a change-over
    #9 slow_sel = 1'b1;
    #25 slow_sel = 1'b0;
    #400;
    high_width(w);
    check(near(w, FAST_HALF), "R5", "fast after aborted switch", w, FAST_HALF);
    #9 slow_sel = 1'b0;
    #3 slow_sel = 1'b1;
    #70 slow_sel = 1'b0;
    #30 slow_sel = 1'b1;
    #400;
    high_width(w);
    check(near(w, SLOW_HALF), "R5", "slow after reversal train", w, SLOW_HALF);

    void'($urandom(32'd1234));
    for (int i = 0; i < 120; i++) begin
      #($urandom_range(3, 300));
      slow_sel = ~slow_sel;
    end
    #400;
    high_width(w);
    check(near(w, slow_sel ? SLOW_HALF : FAST_HALF), "R7", "final selection after random", w,
          slow_sel ? SLOW_HALF : FAST_HALF);

    check(runt_cnt == 0, "R5", "runt pulses", real'(runt_cnt), 0.0);
    check(shape_cnt == 0, "R6", "high pulses of illegal width", real'(shape_cnt), 0.0);
    check(pulse_cnt > 500, "R6", "pulses observed by monitor", real'(pulse_cnt), 500.0);
    check(runt_cnt == 0 && shape_cnt == 0, "R4", "no overlap of sources seen at output",
          real'(runt_cnt + shape_cnt), 0.0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule